// File: doc/BRIEF.md
# Byte-Lane Group ECC Codec

This block sits between a byte-wide access path and a storage array whose words each hold one aligned four-byte group plus its check bits. Each stored word is 39 bits wide. It holds 32 data bits with a 6-bit Hamming code and one overall parity bit, so any single flipped bit can be corrected and any pair of flipped bits can be detected.

A byte read fetches the whole group and corrects a single error in it. The byte lane picked by the two low address bits is then returned. A byte write fetches the group the same way and corrects it. The new byte is merged into its lane, fresh check bits are computed, and the whole group is written back. The other three bytes are therefore rewritten as well, and any stale single error in them is cleared. The byte side sees the same latency whether or not a correction took place.

A one-cycle corrected-error pulse and an uncorrectable flag are brought out so that the behaviour can be observed. A fault-injection input flips one bit of the fetched word on its way into the decoder.

Top module: `grp_ecc_codec`

## Requirements
- R1: A request at byte address A uses group address A[ADDR_W-1:2] on the array port. Lane A[1:0] picks the byte, where lane k is data bits 8k+7..8k.
- R2: A read of a clean group returns the byte most recently written to that address. The initial all-zero array reads back as zero.
- R3: A single flipped bit in any data position of the fetched 39-bit word is corrected. `corr_err` pulses together with the response, and `uncorr_err` stays low.
- R4: A single flipped bit in a check position (word bits 0, 1, 2, 4, 8, 16 and 32) leaves the returned byte unchanged and also pulses `corr_err`.
- R5: Two flipped bits raise `uncorr_err` together with the response and give no `corr_err`. The data passes through uncorrected, so flips at word bits 1 and 2 leave the byte intact.
- R6: A byte write changes only its own lane. The other three bytes of the group read back unchanged.
- R7: A byte write rewrites the whole group with fresh check bits. A single error present before the write is gone afterwards, and a new single error in the same group is still correctable.
- R8: Each request issues exactly one array read. A write then issues exactly one array write in the following cycle. `req_ready` is low from acceptance until the cycle after that write.
- R9: The read response appears in the second cycle after acceptance, whether or not a correction was made.
- R10: After reset, `req_ready` is high and `rsp_valid`, `mem_rd` and `mem_wr` are low.
- R11: A write produces no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Byte request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Codec idle; request accepted when high |
| rsp_valid | output | 1 | Read byte valid |
| rsp_rdata | output | 8 | Read byte |
| corr_err | output | 1 | Single error corrected in this fetch |
| uncorr_err | output | 1 | Double error detected in this fetch |
| mem_rd | output | 1 | Array read strobe; data due next cycle |
| mem_wr | output | 1 | Array write strobe |
| mem_gaddr | output | ADDR_W-2 | Group address |
| mem_wword | output | 39 | Encoded group to store |
| mem_rword | input | 39 | Stored group, one cycle after `mem_rd` |
| inj_en | input | 1 | Flip one fetched bit |
| inj_bit | input | 6 | Bit index to flip (0..38) |

## Verification
The assertions assume that the array returns the word in the cycle right after `mem_rd`. They also assume that `req_valid` is only acted on while `req_ready` is high. The bench's array model registers its read data on every edge, which meets the first assumption. It also presents each request for exactly one accepted cycle. Faults are introduced in two ways: by flipping the model's stored bits between transactions, or by holding `inj_en` steady across a whole transaction. The decoder therefore always sees a stable word.

// File: rtl/grp_ecc_codec.sv
module grp_ecc_codec #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              corr_err,
  output logic              uncorr_err,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-3:0] mem_gaddr,
  output logic [38:0]       mem_wword,
  input  logic [38:0]       mem_rword,
  input  logic              inj_en,
  input  logic [5:0]        inj_bit
);
  localparam int GW = ADDR_W - 2;
  localparam int CW = 39;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DEC} st_t;
  st_t st;
  logic          we_q;
  logic [1:0]    lane_q;
  logic [GW-1:0] gaddr_q;
  logic [7:0]    wdata_q;

  function automatic logic [CW-1:0] encode(input logic [31:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        c[i] = d[k];
        k++;
      end
    for (int p = 0; p < 6; p++)
      for (int i = 1; i < CW; i++)
        if (((i >> p) & 1) == 1 && i != (1 << p)) c[1 << p] = c[1 << p] ^ c[i];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [31:0] extract(input logic [CW-1:0] c);
    logic [31:0] d;
    int k;
    d = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        d[k] = c[i];
        k++;
      end
    return d;
  endfunction

  logic [CW-1:0] fetched, fixed;
  logic [5:0]    syn;
  logic          ovp, single, dbl;
  logic [31:0]   gdata, merged;

  assign fetched = mem_rword ^ ((inj_en ? 39'd1 : 39'd0) << inj_bit);

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW; i++)
      if (fetched[i]) syn = syn ^ 6'(i);
  end

  assign ovp    = ^fetched;
  assign single = ovp && (syn < 6'(CW));
  assign dbl    = (!ovp && syn != 6'd0) || (ovp && syn >= 6'(CW));
  assign fixed  = fetched ^ ((single ? 39'd1 : 39'd0) << syn);
  assign gdata  = extract(fixed);

  always_comb begin
    merged = gdata;
    for (int b = 0; b < 4; b++)
      if (lane_q == 2'(b)) merged[8*b +: 8] = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      we_q    <= 1'b0;
      lane_q  <= '0;
      gaddr_q <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_FETCH;
          we_q    <= req_we;
          lane_q  <= req_addr[1:0];
          gaddr_q <= req_addr[ADDR_W-1:2];
          wdata_q <= req_wdata;
        end
        S_FETCH: st <= S_DEC;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign mem_rd     = (st == S_FETCH);
  assign mem_gaddr  = gaddr_q;
  assign mem_wr     = (st == S_DEC) && we_q;
  assign mem_wword  = encode(merged);
  assign rsp_valid  = (st == S_DEC) && !we_q;
  assign rsp_rdata  = gdata[8*lane_q +: 8];
  assign corr_err   = (st == S_DEC) && single;
  assign uncorr_err = (st == S_DEC) && dbl;

  // R8
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  // R8
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> req_ready);
  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  rsp_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd));
  // R3
  corr_in_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_err |-> (rsp_valid || mem_wr));
  // R5
  corr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_err && uncorr_err));
  // R11
  no_rsp_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_wr));
endmodule

// File: tb/test_grp_ecc_codec.sv
module test_grp_ecc_codec;
  localparam int AW = 10;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, inj_en = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [5:0] inj_bit = '0;
  logic req_ready, rsp_valid, corr_err, uncorr_err, mem_rd, mem_wr;
  logic [7:0] rsp_rdata;
  logic [AW-3:0] mem_gaddr;
  logic [38:0] mem_wword, mem_rword;
  logic [38:0] mem [0:(1<<(AW-2))-1];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  grp_ecc_codec #(.ADDR_W(AW)) i_grp_ecc_codec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .corr_err(corr_err),
    .uncorr_err(uncorr_err), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_gaddr(mem_gaddr), .mem_wword(mem_wword), .mem_rword(mem_rword),
    .inj_en(inj_en), .inj_bit(inj_bit));

  always @(posedge clk) begin
    mem_rword <= mem[mem_gaddr];
    if (mem_wr) mem[mem_gaddr] <= mem_wword;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 busy after accept", req_ready, 0);
    chk(mem_rd == 1, "R8 one fetch", mem_rd, 1);
    chk(mem_gaddr == a[AW-1:2], "R1 group address", mem_gaddr, a[AW-1:2]);
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d, input logic exp_corr);
    issue(1, a, d);
    chk(mem_wr == 1, "R8 writeback", mem_wr, 1);
    chk(rsp_valid == 0, "R11 no response on write", rsp_valid, 0);
    chk(corr_err == exp_corr, "R7 correction during write fetch", corr_err, exp_corr);
    @(negedge clk);
    chk(req_ready && !mem_wr, "R8 ready after writeback", req_ready, 1);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, input logic [7:0] exp, input logic ec,
                         input logic eu, input string tag);
    issue(0, a, 8'h00);
    chk(rsp_valid == 1, {"R9 response timing ", tag}, rsp_valid, 1);
    chk(rsp_rdata == exp, {tag, " data"}, rsp_rdata, exp);
    chk(corr_err == ec, {tag, " corr_err"}, corr_err, ec);
    chk(uncorr_err == eu, {tag, " uncorr_err"}, uncorr_err, eu);
    @(negedge clk);
    chk(!rsp_valid, "R9 single response", rsp_valid, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R10 ready", req_ready, 1);
    chk(!rsp_valid && !mem_rd && !mem_wr, "R10 idle outputs",
        {rsp_valid, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_basic;
    rd_byte(10'd40, 8'h00, 0, 0, "R2 initial zero");
    wr_byte(10'd20, 8'h11, 0);
    wr_byte(10'd21, 8'hA2, 0);
    wr_byte(10'd22, 8'h3C, 0);
    wr_byte(10'd23, 8'hF4, 0);
    rd_byte(10'd20, 8'h11, 0, 0, "R1 R2 lane0");
    rd_byte(10'd21, 8'hA2, 0, 0, "R1 R2 lane1");
    rd_byte(10'd22, 8'h3C, 0, 0, "R1 R2 lane2");
    rd_byte(10'd23, 8'hF4, 0, 0, "R1 R2 lane3");
  endtask

  task automatic t_merge;
    wr_byte(10'd22, 8'h77, 0);
    rd_byte(10'd20, 8'h11, 0, 0, "R6 lane0 kept");
    rd_byte(10'd21, 8'hA2, 0, 0, "R6 lane1 kept");
    rd_byte(10'd22, 8'h77, 0, 0, "R6 lane2 new");
    rd_byte(10'd23, 8'hF4, 0, 0, "R6 lane3 kept");
  endtask

  task automatic t_inject;
    for (int b = 0; b < 39; b++) begin
      @(negedge clk);
      inj_en = 1; inj_bit = 6'(b);
      if ((b & (b - 1)) == 0) rd_byte(10'd21, 8'hA2, 1, 0, "R4 check-bit flip");
      else rd_byte(10'd21, 8'hA2, 1, 0, "R3 data-bit flip");
      inj_en = 0;
    end
  endtask

  task automatic t_double;
    @(negedge clk);
    mem[5] = mem[5] ^ 39'h6;
    rd_byte(10'd20, 8'h11, 0, 1, "R5 double error");
    @(negedge clk);
    mem[5] = mem[5] ^ 39'h6;
    rd_byte(10'd20, 8'h11, 0, 0, "R5 restored");
  endtask

  task automatic t_scrub;
    @(negedge clk);
    mem[7] = mem[7] ^ (39'd1 << 10);
    wr_byte(10'd28, 8'h5A, 1);
    @(negedge clk);
    mem[7] = mem[7] ^ (39'd1 << 20);
    rd_byte(10'd29, 8'h00, 1, 0, "R7 stale error cleared");
    rd_byte(10'd28, 8'h5A, 1, 0, "R7 written byte");
  endtask

  initial begin
    for (int g = 0; g < (1 << (AW - 2)); g++) mem[g] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_merge;
    t_inject;
    t_double;
    t_scrub;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule